// File: doc/BRIEF.md
# Parameterised Serial Frame Transmitter

This block turns a parallel data word into one asynchronous serial frame on a single output line. A frame is a low start bit, the data bits with the least-significant bit first, an optional parity bit and one high stop bit. Each bit holds the line for one bit period. The line sits high whenever no frame is being sent.

The bit period comes from an internal divider. The divider counts system clock cycles up to the clock frequency divided by the baud rate, and it restarts at the beginning of each frame. Data width, parity use and parity sense are fixed by parameters, so the frame length and the state sequence are settled when the block is elaborated.

A client places a word on the data input and pulses the load strobe while the block is not busy. The busy flag covers the whole frame. A one-cycle done pulse marks the cycle in which the stop bit ends, and the next word may be loaded in that same cycle.

Top module: `serial_tx_top`

## Requirements
- R1: After reset the line is high (1), busy is low and done is low.
- R2: A load strobe seen at a clock edge while busy is low starts a frame. From the next cycle, busy is high and the line is low (start bit) for exactly DIV cycles, where DIV = CLK_HZ / BAUD.
- R3: After the start bit, the DATA_W data bits follow in order from bit 0 up to bit DATA_W-1, each held for DIV cycles.
- R4: With PAR_ON = 1, one parity bit of DIV cycles follows the last data bit. It equals the XOR of all data bits when PAR_ODD = 0 (even) and the inverse of that XOR when PAR_ODD = 1 (odd).
- R5: With PAR_ON = 0, the stop bit directly follows the last data bit and the frame is DATA_W + 2 bit periods long.
- R6: The stop bit is high for DIV cycles. Busy falls and done is high for exactly one cycle at the clock edge that ends the stop bit, which is F*DIV cycles after the load edge (F = DATA_W + 2 + PAR_ON).
- R7: A load strobe that arrives while busy is high is ignored: the frame in progress and the number of frames sent do not change.
- R8: A load strobe given in the cycle in which done is high is accepted, so frames can follow each other with a single idle cycle between them.
- R9: The divider reloads after DIV-1 and restarts when a frame begins. Defaults are CLK_HZ = 50000000, BAUD = 9600, DATA_W = 8, PAR_ON = 1 and PAR_ODD = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadReq | input | 1 | Load strobe that starts a frame when idle |
| loadData | input | DATA_W | Word to send, captured with the load strobe |
| serialOut | output | 1 | Registered serial line, high when idle |
| busy | output | 1 | High from frame acceptance until the stop bit ends |
| done | output | 1 | One-cycle pulse when the stop bit ends |

## Verification
A wrong state or bit counter shows on the line as a misplaced or missing bit within one bit period of the fault. A monitor that samples every bit at its midpoint reports it in that frame. A divider that reloads at the wrong count, or that fails to restart, shifts the edges of the frame. Busy and done then change on the wrong cycle, and this is checked against the exact cycle of the load edge. A stale shift register or a load that was wrongly accepted shows up as a mismatched word or an extra frame. The monitor catches either one in the next frame it pops from the scoreboard.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic run;        // divider counts while set
    logic load;       // capture word, restart divider, drive start bit
    logic shift;      // put next data bit on the line
    logic sendParity; // put parity bit on the line
    logic sendStop;   // put stop level on the line
  } txStrobe_t;

endpackage

// File: rtl/serial_tx_datapath.sv
module serial_tx_datapath
  import serial_tx_pkg::*;
#(
  parameter int CLK_HZ  = 50000000,
  parameter int BAUD    = 9600,
  parameter int DATA_W  = 8,
  parameter bit PAR_ON  = 1'b1,
  parameter bit PAR_ODD = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         stb,
  input  logic [DATA_W-1:0] loadData,
  output logic              tick,
  output logic              serialOut
);

  localparam int DIV = CLK_HZ / BAUD;
  localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV - 1);

  logic [CW-1:0]     divCnt;
  logic [DATA_W-1:0] shiftReg;
  logic              parityBit;
  logic              parityNext;

  // bit-period divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (stb.load) begin
      divCnt <= '0;
    end else if (stb.run) begin
      divCnt <= (divCnt == DIV_LAST) ? '0 : divCnt + 1'b1;
    end else begin
      divCnt <= '0;
    end
  end

  assign tick = stb.run && (divCnt == DIV_LAST);

  // parity variant picked by parameters
  generate
    if (PAR_ON) begin : g_parity
      assign parityNext = (^loadData) ^ PAR_ODD;
    end else begin : g_noParity
      assign parityNext = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else if (stb.load) begin
      shiftReg  <= loadData;
      parityBit <= parityNext;
    end else if (stb.shift) begin
      shiftReg  <= {1'b0, shiftReg[DATA_W-1:1]};
    end
  end

  // registered line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serialOut <= 1'b1;
    end else if (stb.load) begin
      serialOut <= 1'b0;
    end else if (stb.shift) begin
      serialOut <= shiftReg[0];
    end else if (stb.sendParity) begin
      serialOut <= parityBit;
    end else if (stb.sendStop) begin
      serialOut <= 1'b1;
    end
  end

  // R9: divider never passes its reload value
  a_r9_div_range: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= DIV_LAST);

  // R9: divider restarts with a new frame
  a_r9_div_restart: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> divCnt == '0);

  // R2: start bit follows a load
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> !serialOut);

endmodule

// File: rtl/serial_tx_control.sv
module serial_tx_control
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit PAR_ON = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadReq,
  input  logic      tick,
  output txStrobe_t stb,
  output logic      busy,
  output logic      done
);

  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

  txState_e      state;
  logic [BW-1:0] bitCnt;

  always_comb begin
    stb     = '0;
    stb.run = busy;
    unique case (state)
      ST_IDLE:   stb.load = loadReq;
      ST_START:  stb.shift = tick;
      ST_DATA: begin
        if (tick) begin
          if (bitCnt == BIT_LAST) begin
            if (PAR_ON) stb.sendParity = 1'b1;
            else        stb.sendStop   = 1'b1;
          end else begin
            stb.shift = 1'b1;
          end
        end
      end
      ST_PARITY: stb.sendStop = tick;
      ST_STOP:   ;
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (loadReq) begin
            state  <= ST_START;
            busy   <= 1'b1;
            bitCnt <= '0;
          end
        end
        ST_START: if (tick) state <= ST_DATA;
        ST_DATA: begin
          if (tick) begin
            if (bitCnt == BIT_LAST) begin
              state <= PAR_ON ? ST_PARITY : ST_STOP;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_PARITY: if (tick) state <= ST_STOP;
        ST_STOP: begin
          if (tick) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: busy falls together with the done pulse
  a_r6_done_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R6: done lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: a load during a frame does not end it early
  a_r7_load_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && loadReq && state != ST_STOP) |=> busy);

  // R2: idle load makes the block busy
  a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && loadReq) |=> busy);

  // R5: no parity state without parity
  a_r5_no_parity_state: assert property (@(posedge clk) disable iff (!rstN)
    !PAR_ON |-> state != ST_PARITY);

endmodule

// File: rtl/serial_tx_top.sv
module serial_tx_top
  import serial_tx_pkg::*;
#(
  parameter int CLK_HZ  = 50000000,
  parameter int BAUD    = 9600,
  parameter int DATA_W  = 8,
  parameter bit PAR_ON  = 1'b1,
  parameter bit PAR_ODD = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadReq,
  input  logic [DATA_W-1:0] loadData,
  output logic              serialOut,
  output logic              busy,
  output logic              done
);

  txStrobe_t stb;
  logic      tick;

  serial_tx_control #(
    .DATA_W (DATA_W),
    .PAR_ON (PAR_ON)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadReq (loadReq),
    .tick    (tick),
    .stb     (stb),
    .busy    (busy),
    .done    (done)
  );

  serial_tx_datapath #(
    .CLK_HZ  (CLK_HZ),
    .BAUD    (BAUD),
    .DATA_W  (DATA_W),
    .PAR_ON  (PAR_ON),
    .PAR_ODD (PAR_ODD)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .loadData  (loadData),
    .tick      (tick),
    .serialOut (serialOut)
  );

  // R1: idle line is high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> serialOut);

endmodule

// File: tb/sim_serial_tx_top.sv
module sim_serial_tx_top;

  localparam int DIV    = 8;
  localparam int NCFG   = 3;
  localparam int NWORDS = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic       loadReq [NCFG];
  logic [7:0] loadData[NCFG];
  logic       lineO   [NCFG];
  logic       busyO   [NCFG];
  logic       doneO   [NCFG];

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[NCFG][$];
  int framesSeen[NCFG];

  // config 0: even parity, 1: odd parity, 2: no parity
  serial_tx_top #(.CLK_HZ(8), .BAUD(1), .DATA_W(8), .PAR_ON(1'b1), .PAR_ODD(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .loadReq(loadReq[0]), .loadData(loadData[0]),
    .serialOut(lineO[0]), .busy(busyO[0]), .done(doneO[0]));
  serial_tx_top #(.CLK_HZ(8), .BAUD(1), .DATA_W(8), .PAR_ON(1'b1), .PAR_ODD(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .loadReq(loadReq[1]), .loadData(loadData[1]),
    .serialOut(lineO[1]), .busy(busyO[1]), .done(doneO[1]));
  serial_tx_top #(.CLK_HZ(8), .BAUD(1), .DATA_W(8), .PAR_ON(1'b0), .PAR_ODD(1'b0)) u2 (
    .clk(clk), .rstN(rstN), .loadReq(loadReq[2]), .loadData(loadData[2]),
    .serialOut(lineO[2]), .busy(busyO[2]), .done(doneO[2]));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cfg actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic driver(input int c);
    for (int v = 0; v < NWORDS; v++) begin
      bit b2b;
      @(negedge clk);
      while (busyO[c]) @(negedge clk);
      if (v % 16 == 5) repeat (3) @(negedge clk);
      b2b = doneO[c];
      loadReq[c]  = 1'b1;
      loadData[c] = 8'(v);
      expQ[c].push_back(8'(v));
      @(negedge clk);
      loadReq[c] = 1'b0;
      if (b2b) begin
        // R8: load in the done cycle accepted at once
        check(busyO[c] === 1'b1 && lineO[c] === 1'b0, "R8", int'(busyO[c]), 1);
      end
      if (v % 7 == 3) begin
        repeat (2 * DIV) @(negedge clk);
        loadReq[c]  = 1'b1;   // R7: ignored while busy
        loadData[c] = ~8'(v);
        @(negedge clk);
        loadReq[c] = 1'b0;
      end
    end
  endtask

  task automatic monitor(input int c, input bit parOn, input bit odd);
    int nBits;
    nBits = parOn ? 11 : 10;
    while (framesSeen[c] < NWORDS) begin
      logic [7:0] exp;
      logic       expPar;
      @(negedge clk);
      if (lineO[c] !== 1'b0) continue;
      // offset 0: first cycle of start bit
      check(busyO[c] === 1'b1, "R2", int'(busyO[c]), 1);
      if (expQ[c].size() == 0) begin
        check(1'b0, "R7", framesSeen[c] + 1, framesSeen[c]);
        exp = 8'h00;
      end else begin
        exp = expQ[c].pop_front();
      end
      framesSeen[c]++;
      repeat (DIV / 2) @(negedge clk);
      check(lineO[c] === 1'b0, "R2", int'(lineO[c]), 0);
      for (int i = 0; i < 8; i++) begin
        repeat (DIV) @(negedge clk);
        check(lineO[c] === exp[i], "R3", int'(lineO[c]), int'(exp[i]));
      end
      if (parOn) begin
        expPar = (^exp) ^ odd;
        repeat (DIV) @(negedge clk);
        check(lineO[c] === expPar, "R4", int'(lineO[c]), int'(expPar));
      end
      repeat (DIV) @(negedge clk);
      if (parOn) check(lineO[c] === 1'b1, "R6", int'(lineO[c]), 1);
      else       check(lineO[c] === 1'b1, "R5", int'(lineO[c]), 1);
      // now at offset DIV/2 + (nBits-1)*DIV; walk to nBits*DIV - 1
      repeat (DIV / 2 - 1) @(negedge clk);
      check(busyO[c] === 1'b1 && doneO[c] === 1'b0, "R6", int'(busyO[c]), 1);
      @(negedge clk);
      // R9: frame length is nBits * DIV cycles
      check(busyO[c] === 1'b0 && doneO[c] === 1'b1, "R6", int'(doneO[c]), 1);
      if (nBits == 10) check(busyO[c] === 1'b0, "R5", int'(busyO[c]), 0);
    end
  endtask

  initial begin
    bit timedOut;
    timedOut = 1'b0;
    for (int c = 0; c < NCFG; c++) begin
      loadReq[c] = 1'b0;
      loadData[c] = 8'h00;
      framesSeen[c] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int c = 0; c < NCFG; c++) begin
      check(lineO[c] === 1'b1, "R1", int'(lineO[c]), 1);
      check(busyO[c] === 1'b0 && doneO[c] === 1'b0, "R1", int'(busyO[c]), 0);
    end
    rstN = 1'b1;
    @(negedge clk);
    fork
      begin
        fork
          driver(0);
          driver(1);
          driver(2);
          monitor(0, 1'b1, 1'b0);
          monitor(1, 1'b1, 1'b1);
          monitor(2, 1'b0, 1'b0);
        join
      end
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) check(1'b0, "watchdog", 0, 1);
    // R7: no extra frames after the last word
    repeat (4 * DIV) @(negedge clk);
    for (int c = 0; c < NCFG; c++) begin
      check(framesSeen[c] == NWORDS, "R7", framesSeen[c], NWORDS);
      check(expQ[c].size() == 0, "R7", expQ[c].size(), 0);
      check(lineO[c] === 1'b1 && busyO[c] === 1'b0, "R7", int'(lineO[c]), 1);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule